// File: doc/BRIEF.md
# Nine-Bit Serial Receiver with Address Filter

This block receives asynchronous serial frames of eleven bits each: a low start bit, eight data bits (least significant first), a ninth bit and a stop bit. It does not generate its own baud timing. An external timer gives it single-cycle tick pulses, sixteen per bit time. A four-bit phase counter advances on every tick, so one full round of the counter covers one bit. The serial line first passes through a two-flop synchronizer. While the receiver is idle, the counter is held at zero. A high-to-low transition of the synchronized line then starts a frame.

Each bit is sampled at phase counts 7, 8 and 9, and the bit takes the majority value of those three samples. A start bit whose majority is high is treated as noise, and the receiver goes back to idle. At the decision point of the ninth-bit period, the received byte and the ninth bit are copied to the outputs only if the receive flag is clear. In address-filter mode the ninth bit must also be 1. This lets a node on a shared line ignore data frames until an address frame arrives. The receive flag rises at the stop-bit decision point of a copied frame and stays set until software clears it.

Top module: `mp_serial_rx`

## Requirements
- R1: After reset, rx_byte is 0, rx_ninth is 0, rx_flag is 0 and the receiver is idle.
- R2: While idle, the phase counter is held at 0, and a line that stays high never raises rx_flag. After a start, the counter advances by exactly one on each tick and stays unchanged on cycles without a tick, wrapping from 15 to 0 once per bit.
- R3: The start bit is sampled at phase counts 7, 8 and 9. If two or three of those samples are high, the receiver returns to idle at count 10, leaving rx_byte, rx_ninth and rx_flag unchanged, and it then accepts the next valid frame.
- R4: Every data bit takes the majority of its three samples, so one corrupted sample inside a bit does not change the received value.
- R5: The first data bit after the start bit lands in rx_byte bit 0, and the eighth lands in bit 7.
- R6: At phase count 10 of the ninth-bit period, rx_byte and rx_ninth are loaded when rx_flag is 0 and either mp_en is 0 or the ninth bit is 1.
- R7: When that load condition fails (rx_flag already 1, or mp_en is 1 with a ninth bit of 0), rx_byte, rx_ninth and rx_flag all stay unchanged.
- R8: rx_flag is set at phase count 10 of the stop-bit period, only for a frame that was loaded. The receiver then returns to idle and starts the next frame on the next high-to-low transition.
- R9: rx_flag stays at 1 until rx_clr is high on a clock edge, and then reads 0 from the next cycle. If a set and a clear fall on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle oversampling pulse, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| mp_en | input | 1 | Address-filter mode: load only frames whose ninth bit is 1 |
| rx_clr | input | 1 | Clears the receive flag |
| rx_byte | output | DATA_W | Last loaded data byte |
| rx_ninth | output | 1 | Ninth bit of the last loaded frame |
| rx_flag | output | 1 | Receive flag |

## Verification
On every cycle the assertions check the phase counter: it is held at zero while idle and steps by one only on ticks. They also check the flag: it persists and clears as specified, and it rises only after a stop-bit completion of a loaded frame. The outputs change only on a load, and a load never happens while the flag is set. Only the bench scenarios can show the rest, because these outcomes are the end result of whole frames. That covers the received value, the bit order, the filter decision for each byte, rejection of a short glitch taken as a start, and the immunity of the vote to a single corrupted sample.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_START = 3'd1,
      PH_DATA  = 3'd2,
      PH_NINTH = 3'd3,
      PH_STOP  = 3'd4
   } phase_t;
endpackage

// File: rtl/rxs_sync.sv
module rxs_sync #(
   parameter int   STAGES    = 2,
   parameter logic IDLE_LVL  = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout,
   output logic fall
);
   localparam int DEPTH = STAGES + 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("rxs_sync: STAGES must be at least 2");
   end

   logic [DEPTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {DEPTH{IDLE_LVL}};
      else        pipe <= {pipe[DEPTH-2:0], din};
   end

   assign dout = pipe[STAGES-1];
   assign fall = pipe[STAGES] & ~pipe[STAGES-1];
endmodule

// File: rtl/rxs_vote.sv
module rxs_vote #(
   parameter int CNT_W    = 4,
   parameter int MID      = 8,
   parameter bit MAJORITY = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [CNT_W-1:0] cnt,
   input  logic             line,
   output logic             bit_val
);
   localparam logic [CNT_W-1:0] P_LO  = CNT_W'(MID - 1);
   localparam logic [CNT_W-1:0] P_MID = CNT_W'(MID);
   localparam logic [CNT_W-1:0] P_HI  = CNT_W'(MID + 1);

   if (MID < 1 || MID + 2 > (1 << CNT_W) - 1) begin : g_bad_mid
      $error("rxs_vote: sample window must fit inside the phase counter");
   end

   if (MAJORITY) begin : g_majority
      logic [2:0] smp;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            smp <= 3'b111;
         end else if (tick) begin
            if (cnt == P_LO)  smp[0] <= line;
            if (cnt == P_MID) smp[1] <= line;
            if (cnt == P_HI)  smp[2] <= line;
         end
      end
      assign bit_val = (smp[0] & smp[1]) | (smp[0] & smp[2]) | (smp[1] & smp[2]);
   end else begin : g_single
      logic smp;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     smp <= 1'b1;
         else if (tick && cnt == P_MID)  smp <= line;
      end
      assign bit_val = smp;
   end
endmodule

// File: rtl/rxs_frame.sv
module rxs_frame
   import rxs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4,
   parameter int DECIDE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              start_edge,
   input  logic              bit_val,
   input  logic              mp_en,
   input  logic              flag_now,
   output phase_t            phase,
   output logic [CNT_W-1:0]  cnt,
   output logic [DATA_W-1:0] shreg,
   output logic              ld_pulse,
   output logic              done_pulse
);
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] DEC_CNT  = CNT_W'(DECIDE);

   if (DATA_W < 2) begin : g_bad_width
      $error("rxs_frame: DATA_W must be at least 2");
   end
   if (DECIDE >= (1 << CNT_W)) begin : g_bad_decide
      $error("rxs_frame: decision count exceeds phase counter range");
   end

   logic [IDX_W-1:0] idx;
   logic             loaded;
   logic             at_dec;

   assign at_dec     = tick && (cnt == DEC_CNT);
   assign ld_pulse   = (phase == PH_NINTH) && at_dec && !flag_now && (!mp_en || bit_val);
   assign done_pulse = (phase == PH_STOP) && at_dec && loaded;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         idx    <= '0;
         shreg  <= '0;
         loaded <= 1'b0;
      end else if (phase == PH_IDLE) begin
         cnt <= '0;
         if (start_edge) begin
            phase  <= PH_START;
            loaded <= 1'b0;
         end
      end else if (tick) begin
         cnt <= cnt + 1'b1;
         if (cnt == DEC_CNT) begin
            unique case (phase)
               PH_START: begin
                  if (bit_val) begin
                     phase <= PH_IDLE;
                     cnt   <= '0;
                  end else begin
                     phase <= PH_DATA;
                     idx   <= '0;
                  end
               end
               PH_DATA: begin
                  shreg <= {bit_val, shreg[DATA_W-1:1]};
                  if (idx == LAST_IDX) phase <= PH_NINTH;
                  else                 idx   <= idx + 1'b1;
               end
               PH_NINTH: begin
                  loaded <= ld_pulse;
                  phase  <= PH_STOP;
               end
               PH_STOP: begin
                  phase <= PH_IDLE;
                  cnt   <= '0;
               end
               default: phase <= PH_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/mp_serial_rx.sv
module mp_serial_rx
   import rxs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CNT_W       = 4,
   parameter int SAMPLE_MID  = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit MAJORITY    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd,
   input  logic              mp_en,
   input  logic              rx_clr,
   output logic [DATA_W-1:0] rx_byte,
   output logic              rx_ninth,
   output logic              rx_flag
);
   localparam int DECIDE = SAMPLE_MID + 2;

   logic              line_s;
   logic              start_edge;
   logic              bit_val;
   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic [DATA_W-1:0] shreg;
   logic              ld_pulse;
   logic              done_pulse;

   rxs_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (rxd),
      .dout (line_s),
      .fall (start_edge)
   );

   rxs_vote #(.CNT_W(CNT_W), .MID(SAMPLE_MID), .MAJORITY(MAJORITY)) u_vote (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .cnt    (cnt),
      .line   (line_s),
      .bit_val(bit_val)
   );

   rxs_frame #(.DATA_W(DATA_W), .CNT_W(CNT_W), .DECIDE(DECIDE)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .start_edge(start_edge),
      .bit_val   (bit_val),
      .mp_en     (mp_en),
      .flag_now  (rx_flag),
      .phase     (phase),
      .cnt       (cnt),
      .shreg     (shreg),
      .ld_pulse  (ld_pulse),
      .done_pulse(done_pulse)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_byte  <= '0;
         rx_ninth <= 1'b0;
      end else if (ld_pulse) begin
         rx_byte  <= shreg;
         rx_ninth <= bit_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          rx_flag <= 1'b0;
      else if (done_pulse) rx_flag <= 1'b1;
      else if (rx_clr)     rx_flag <= 1'b0;
   end
endmodule

// File: rtl/rxs_chk.sv
module rxs_chk
   import rxs_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic              rx_clr,
   input logic              rx_flag,
   input logic [DATA_W-1:0] rx_byte,
   input logic              rx_ninth,
   input logic              ld_pulse,
   input logic              done_pulse,
   input phase_t            phase,
   input logic [CNT_W-1:0]  cnt
);
   a_r2_idle_held: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_IDLE) |-> (cnt == '0));

   a_r2_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cnt));

   a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && phase != PH_IDLE) |=> ((cnt == CNT_W'($past(cnt) + 1'b1)) || (phase == PH_IDLE)));

   a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_flag && !rx_clr) |=> rx_flag);

   a_r9_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_clr && !done_pulse) |=> !rx_flag);

   a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_flag ##1 rx_flag) |-> $past(done_pulse));

   a_r7_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_pulse |=> ($stable(rx_byte) && $stable(rx_ninth)));

   a_r6_no_load_when_set: assert property (@(posedge clk) disable iff (!rst_n)
      ld_pulse |-> !rx_flag);
endmodule

bind mp_serial_rx rxs_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .rx_clr    (rx_clr),
   .rx_flag   (rx_flag),
   .rx_byte   (rx_byte),
   .rx_ninth  (rx_ninth),
   .ld_pulse  (ld_pulse),
   .done_pulse(done_pulse),
   .phase     (phase),
   .cnt       (cnt)
);

// File: tb/sim_mp_serial_rx.sv
module sim_mp_serial_rx;
   localparam int BIT_CLKS = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       rxd = 1'b1;
   logic       mp_en = 1'b0;
   logic       rx_clr = 1'b0;
   logic [7:0] rx_byte;
   logic       rx_ninth;
   logic       rx_flag;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  finished = 1'b0;

   logic [7:0] e_byte = 8'h00;
   logic       e_ninth = 1'b0;
   logic       e_flag = 1'b0;

   mp_serial_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .mp_en(mp_en),
      .rx_clr(rx_clr), .rx_byte(rx_byte), .rx_ninth(rx_ninth), .rx_flag(rx_flag)
   );

   always #10 clk = ~clk;

   initial begin
      forever begin
         @(negedge clk) tick = 1'b1;
         @(negedge clk) tick = 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hold_line(input logic v, input int clks);
      rxd = v;
      repeat (clks) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input logic nb, input bit glitch);
      hold_line(1'b0, BIT_CLKS);
      for (int k = 0; k < 8; k++) begin
         if (glitch) begin
            hold_line(b[k], 16);
            hold_line(~b[k], 2);
            hold_line(b[k], BIT_CLKS - 18);
         end else begin
            hold_line(b[k], BIT_CLKS);
         end
      end
      hold_line(nb, BIT_CLKS);
      hold_line(1'b1, BIT_CLKS);
      hold_line(1'b1, 40);
   endtask

   task automatic clear_flag();
      rx_clr = 1'b1;
      @(negedge clk);
      rx_clr = 1'b0;
      e_flag = 1'b0;
   endtask

   task automatic model_frame(input logic [7:0] b, input logic nb);
      if (!e_flag && (!mp_en || nb)) begin
         e_byte  = b;
         e_ninth = nb;
         e_flag  = 1'b1;
      end
   endtask

   task automatic check_outputs(input string req);
      check({req, " byte"},  32'(rx_byte),  32'(e_byte));
      check({req, " ninth"}, 32'(rx_ninth), 32'(e_ninth));
      check({req, " flag"},  32'(rx_flag),  32'(e_flag));
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] b;
      logic       nb;
      repeat (5) @(negedge clk);
      // R1: reset values
      check("R1 byte",  32'(rx_byte),  32'h0);
      check("R1 ninth", 32'(rx_ninth), 32'h0);
      check("R1 flag",  32'(rx_flag),  32'h0);
      rst_n = 1'b1;
      // R2: idle line high for many bit times, nothing received
      repeat (400) @(negedge clk);
      check("R2 idle flag", 32'(rx_flag), 32'h0);

      // R5 / R6 / R7 / R8: sweep every byte value
      for (int i = 0; i < 256; i++) begin
         b     = 8'(i);
         nb    = b[0] ^ b[3] ^ b[7];
         mp_en = b[1];
         if ((i % 16) != 5) clear_flag();
         if (i < 3) check("R9 cleared", 32'(rx_flag), 32'h0);
         send_frame(b, nb, 1'b0);
         model_frame(b, nb);
         if (e_flag && e_byte == b && e_ninth == nb) check_outputs("R6 R5 R8 load");
         else                                         check_outputs("R7 filtered");
      end

      // R9: flag holds without clear, then clears
      mp_en = 1'b0;
      clear_flag();
      send_frame(8'hA5, 1'b0, 1'b0);
      model_frame(8'hA5, 1'b0);
      repeat (300) @(negedge clk);
      check("R9 hold", 32'(rx_flag), 32'h1);
      clear_flag();
      check("R9 clear", 32'(rx_flag), 32'h0);

      // R3: false start (line low for only two ticks) is rejected
      hold_line(1'b0, 4);
      hold_line(1'b1, 600);
      check_outputs("R3 false start");
      send_frame(8'h3C, 1'b1, 1'b0);
      model_frame(8'h3C, 1'b1);
      check_outputs("R3 recovery");

      // R4: one corrupted sample per data bit
      for (int j = 0; j < 6; j++) begin
         b  = 8'(8'h5A ^ (8'(j) * 8'h27));
         nb = b[2];
         mp_en = 1'b0;
         clear_flag();
         send_frame(b, nb, 1'b1);
         model_frame(b, nb);
         check_outputs("R4 vote");
      end

      // R6: address-filter mode accepts ninth=1 after a rejected ninth=0
      mp_en = 1'b1;
      clear_flag();
      send_frame(8'hC3, 1'b0, 1'b0);
      model_frame(8'hC3, 1'b0);
      check_outputs("R7 mp reject");
      send_frame(8'h81, 1'b1, 1'b0);
      model_frame(8'h81, 1'b1);
      check_outputs("R6 mp accept");

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule